// File: doc/BRIEF.md
# Scheduled Receive Capture and Bit-Error Checker

This block sits on the receive side of a line card behind a deserializer. Parallel words arrive in the clock recovered from the serial link. A word is written into a fixed-depth receive buffer only in the slots the switch schedule marks as "receive here". Every other word is dropped. When the buffer holds its last word, capture stops for good. The full condition crosses into the system clock domain and raises an interrupt.

At the same moment a checker in the system domain starts to walk the frozen buffer. For each stored word it compares the word with a locally generated pseudo-random expected word and adds the number of differing bits to a saturating error counter. Software reads the status and the count through a small read-only register port. Software then acknowledges the interrupt, which also rearms the capture pointer for the next run.

Top module: `rx_sched_checker`

## Requirements
- R1: After reset, `irq` is 0, the status register (address 0) reads 0 and the error count register (address 1) reads 0.
- R2: A word on `rx_word` is stored only in an `rx_clk` cycle where `rx_valid` and `rx_take` are both 1. Words with either signal at 0 are neither stored nor counted.
- R3: Once DEPTH words have been stored, all further words are ignored until a clear. They neither overwrite the buffer nor change the error count.
- R4: `irq` rises a few system cycles after the DEPTH-th stored word. It then stays at 1 until `irq_clr` is pulsed.
- R5: The error count is the sum, over buffer entries k = 0..DEPTH-1, of the number of 1 bits in (stored word k XOR expected word k). Expected word 0 is `seed`. Expected word k+1 is {e[14:0], e[15]^e[14]^e[12]^e[3]} of expected word k.
- R6: The error count saturates at 2^ERR_W-1 instead of wrapping.
- R7: A one-cycle `irq_clr` pulse clears `irq`, the done flag and the error count on the next system cycle. It also returns the write pointer to entry 0 and releases the full state, even when a capture run is only partly done.
- R8: Address 0 reads {13'b0, full, done, irq}: bit 0 is the interrupt, bit 1 is set when checking of all DEPTH entries has finished, and bit 2 is the synchronized full flag.
- R9: After only DEPTH-1 stored words, `irq` and the full bit stay at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| rx_clk | input | 1 | Clock recovered from the serial link |
| rx_rst | input | 1 | Synchronous active-high reset, recovered-clock domain |
| rx_valid | input | 1 | Deserializer word valid |
| rx_take | input | 1 | Schedule grant: this slot is for this port |
| rx_word | input | 16 | Parallel received word |
| seed | input | 16 | Start value of the expected pattern |
| irq_clr | input | 1 | Interrupt acknowledge and rearm, system domain |
| rd_addr | input | 2 | Register address |
| rd_data | output | 16 | Register read data |
| irq | output | 1 | Buffer-full interrupt |

## Verification
The bench mixes junk words with only `rx_valid` or only `rx_take` high among the scheduled words. A gate that ignored either signal would store junk and report a nonzero error count on a clean pattern. It stops one word short of full to catch an interrupt raised early. It then feeds junk after the buffer is full: a pointer that wrapped instead of stopping would overwrite entry 0 and show errors. All-inverted data pushes the count past the counter width, so a wrapping counter would read far below its ceiling. A clear in the middle of a run followed by a clean run exposes a pointer that was not rearmed, because the clean words would land at the wrong entries.

// File: rtl/rxchk_pkg.sv
package rxchk_pkg;
    localparam int WORD_W = 16;
    localparam int PC_W   = $clog2(WORD_W + 1);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PC_W-1:0]   pcnt_t;

    typedef enum logic [1:0] {CHK_IDLE, CHK_RUN, CHK_DONE} chk_state_t;

    typedef struct packed {
        logic full;
        logic done;
        logic irq;
    } status_t;

    localparam logic [1:0] ADDR_STATUS = 2'd0;
    localparam logic [1:0] ADDR_ERRS   = 2'd1;

    // x^16 + x^15 + x^13 + x^4 + 1, shifting left
    function automatic word_t next_word(word_t w);
        return {w[WORD_W-2:0], w[15] ^ w[14] ^ w[12] ^ w[3]};
    endfunction

    function automatic pcnt_t popcount(word_t w);
        pcnt_t c = '0;
        for (int i = 0; i < WORD_W; i++) c = c + pcnt_t'(w[i]);
        return c;
    endfunction
endpackage

// File: rtl/rxchk_sync2.sv
module rxchk_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta;
    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/rxchk_capture.sv
module rxchk_capture
    import rxchk_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             in_valid,
    input  logic             in_take,
    input  word_t            in_word,
    input  logic [PTR_W-1:0] rd_idx,
    output word_t            rd_word,
    output logic             full,
    output logic [PTR_W-1:0] wptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    word_t mem [DEPTH];
    logic  accept;

    assign accept = in_valid && in_take && !full && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr <= '0;
            full <= 1'b0;
        end else if (accept) begin
            wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (wptr == LAST) full <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) mem[wptr] <= in_word;
    end

    // buffer is frozen while the system side reads it
    assign rd_word = mem[rd_idx];
endmodule

// File: rtl/rxchk_errcount.sv
module rxchk_errcount
    import rxchk_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int ERR_W = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             clr,
    input  word_t            seed,
    output logic [PTR_W-1:0] rd_idx,
    input  word_t            rd_word,
    output logic [ERR_W-1:0] err_cnt,
    output logic             done
);
    localparam int SUM_W = ERR_W + PC_W;
    localparam logic [SUM_W-1:0] ERR_MAX = SUM_W'((64'd1 << ERR_W) - 64'd1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    chk_state_t       state;
    word_t            expect_w;
    logic [SUM_W-1:0] sum;
    logic [ERR_W-1:0] err_next;

    always_comb begin
        sum      = SUM_W'(err_cnt) + SUM_W'(popcount(rd_word ^ expect_w));
        err_next = (sum > ERR_MAX) ? ERR_MAX[ERR_W-1:0] : sum[ERR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state    <= CHK_IDLE;
            rd_idx   <= '0;
            expect_w <= '0;
            err_cnt  <= '0;
        end else begin
            case (state)
                CHK_RUN: begin
                    err_cnt  <= err_next;
                    expect_w <= next_word(expect_w);
                    rd_idx   <= rd_idx + 1'b1;
                    if (rd_idx == LAST) state <= CHK_DONE;
                end
                default: if (start) begin
                    state    <= CHK_RUN;
                    rd_idx   <= '0;
                    expect_w <= seed;
                    err_cnt  <= '0;
                end
            endcase
        end
    end

    assign done = (state == CHK_DONE);
endmodule

// File: rtl/rx_sched_checker.sv
module rx_sched_checker
    import rxchk_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int ERR_W = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              sys_clk,
    input  logic              sys_rst,
    input  logic              rx_clk,
    input  logic              rx_rst,
    input  logic              rx_valid,
    input  logic              rx_take,
    input  logic [WORD_W-1:0] rx_word,
    input  logic [WORD_W-1:0] seed,
    input  logic              irq_clr,
    input  logic [1:0]        rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              irq
);
    // clear request: toggle in system domain, edge in rx domain
    logic clr_tgl, clr_s, clr_s_d, clr_pulse;
    always_ff @(posedge sys_clk) begin
        if (sys_rst)      clr_tgl <= 1'b0;
        else if (irq_clr) clr_tgl <= ~clr_tgl;
    end
    rxchk_sync2 u_clr_sync (.clk(rx_clk), .rst(rx_rst), .d(clr_tgl), .q(clr_s));
    always_ff @(posedge rx_clk) begin
        if (rx_rst) clr_s_d <= 1'b0;
        else        clr_s_d <= clr_s;
    end
    assign clr_pulse = clr_s ^ clr_s_d;

    logic             cap_full;
    logic [PTR_W-1:0] cap_wptr;
    logic [PTR_W-1:0] chk_idx;
    word_t            chk_word;

    rxchk_capture #(.DEPTH(DEPTH)) u_cap (
        .clk(rx_clk), .rst(rx_rst), .clr(clr_pulse),
        .in_valid(rx_valid), .in_take(rx_take), .in_word(rx_word),
        .rd_idx(chk_idx), .rd_word(chk_word),
        .full(cap_full), .wptr(cap_wptr)
    );

    // full flag into the system domain
    logic full_s, full_s_d, full_rise, chk_start, chk_done;
    rxchk_sync2 u_full_sync (.clk(sys_clk), .rst(sys_rst), .d(cap_full), .q(full_s));
    always_ff @(posedge sys_clk) begin
        if (sys_rst) full_s_d <= 1'b0;
        else         full_s_d <= full_s;
    end
    assign full_rise = full_s && !full_s_d;
    assign chk_start = full_rise && !irq_clr;

    always_ff @(posedge sys_clk) begin
        if (sys_rst || irq_clr) irq <= 1'b0;
        else if (full_rise)     irq <= 1'b1;
    end

    logic [ERR_W-1:0] err_cnt;
    rxchk_errcount #(.DEPTH(DEPTH), .ERR_W(ERR_W)) u_chk (
        .clk(sys_clk), .rst(sys_rst), .start(chk_start), .clr(irq_clr),
        .seed(seed), .rd_idx(chk_idx), .rd_word(chk_word),
        .err_cnt(err_cnt), .done(chk_done)
    );

    status_t status;
    always_comb begin
        status = '{full: full_s, done: chk_done, irq: irq};
        case (rd_addr)
            ADDR_STATUS: rd_data = WORD_W'(status);
            ADDR_ERRS:   rd_data = WORD_W'(err_cnt);
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/rx_sched_checker_sva.sv
module rx_sched_checker_sva #(
    parameter int PTR_W = 4,
    parameter int ERR_W = 16
) (
    input logic             sys_clk,
    input logic             sys_rst,
    input logic             rx_clk,
    input logic             rx_rst,
    input logic             rx_valid,
    input logic             rx_take,
    input logic             irq,
    input logic             irq_clr,
    input logic             full_s,
    input logic             cap_full,
    input logic [PTR_W-1:0] cap_wptr,
    input logic             clr_pulse,
    input logic             chk_start,
    input logic             chk_done,
    input logic [ERR_W-1:0] err_cnt
);
    a_r2_no_write_unscheduled: assert property (@(posedge rx_clk) disable iff (rx_rst)
        (!(rx_valid && rx_take) && !clr_pulse) |=> $stable(cap_wptr));

    a_r3_no_write_when_full: assert property (@(posedge rx_clk) disable iff (rx_rst)
        (cap_full && !clr_pulse) |=> ($stable(cap_wptr) && cap_full));

    a_r4_irq_holds: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (irq && !irq_clr) |=> irq);

    a_r9_irq_needs_full: assert property (@(posedge sys_clk) disable iff (sys_rst)
        $rose(irq) |-> full_s);

    a_r8_done_with_irq: assert property (@(posedge sys_clk) disable iff (sys_rst)
        chk_done |-> irq);

    a_r6_err_no_decrease: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (!irq_clr && !chk_start) |=> (err_cnt >= $past(err_cnt)));

    a_r7_clear_effect: assert property (@(posedge sys_clk) disable iff (sys_rst)
        irq_clr |=> (!irq && !chk_done && err_cnt == '0));
endmodule

bind rx_sched_checker rx_sched_checker_sva #(.PTR_W(PTR_W), .ERR_W(ERR_W)) u_sva (
    .sys_clk(sys_clk), .sys_rst(sys_rst), .rx_clk(rx_clk), .rx_rst(rx_rst),
    .rx_valid(rx_valid), .rx_take(rx_take), .irq(irq), .irq_clr(irq_clr),
    .full_s(full_s), .cap_full(cap_full), .cap_wptr(cap_wptr),
    .clr_pulse(clr_pulse), .chk_start(chk_start), .chk_done(chk_done),
    .err_cnt(err_cnt)
);

// File: tb/test_rx_sched_checker.sv
module test_rx_sched_checker;
    localparam int DEPTH = 16;
    localparam int ERR_W = 8;
    localparam int ERR_MAX = (1 << ERR_W) - 1;

    logic        sys_clk = 0, rx_clk = 0;
    logic        sys_rst = 1, rx_rst = 1;
    logic        rx_valid = 0, rx_take = 0;
    logic [15:0] rx_word = 0, seed = 0;
    logic        irq_clr = 0;
    logic [1:0]  rd_addr = 0;
    logic [15:0] rd_data;
    logic        irq;

    always #10 sys_clk = ~sys_clk;
    always #8  rx_clk  = ~rx_clk;

    rx_sched_checker #(.DEPTH(DEPTH), .ERR_W(ERR_W)) i_rx_sched_checker (
        .sys_clk(sys_clk), .sys_rst(sys_rst), .rx_clk(rx_clk), .rx_rst(rx_rst),
        .rx_valid(rx_valid), .rx_take(rx_take), .rx_word(rx_word),
        .seed(seed), .irq_clr(irq_clr), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    int n_checks = 0, n_fail = 0, mon_runs = 0;
    int exp_q[$];
    int m_cnt, m_err;
    bit [15:0] m_exp, g;

    function automatic bit [15:0] lfsr_step(bit [15:0] w);
        return {w[14:0], w[15] ^ w[14] ^ w[12] ^ w[3]};
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge sys_clk);
        rd_addr = a;
        #1 v = int'(rd_data);
    endtask

    task automatic sys_wait(int n);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic start_run(bit [15:0] s);
        seed = s; m_exp = s; m_cnt = 0; m_err = 0; g = s;
    endtask

    // driver: one rx slot, model pushes expected count when the buffer fills
    task automatic send(bit [15:0] d, bit v, bit t);
        @(negedge rx_clk);
        rx_valid = v; rx_take = t; rx_word = d;
        if (v && t && m_cnt < DEPTH) begin
            m_err += $countones(d ^ m_exp);
            m_exp = lfsr_step(m_exp);
            m_cnt++;
            if (m_cnt == DEPTH) exp_q.push_back(m_err > ERR_MAX ? ERR_MAX : m_err);
        end
    endtask

    task automatic rx_idle();
        @(negedge rx_clk);
        rx_valid = 0; rx_take = 0;
    endtask

    task automatic clear();
        @(negedge sys_clk); irq_clr = 1;
        @(negedge sys_clk); irq_clr = 0;
        repeat (8) @(negedge rx_clk);
    endtask

    task automatic wait_runs(int n);
        while (mon_runs < n) @(negedge sys_clk);
    endtask

    // monitor: on each interrupt wait for done, pop and compare the count
    initial begin
        int st, ec, pop;
        forever begin
            @(negedge sys_clk);
            if (irq && exp_q.size() > 0) begin
                for (int i = 0; i < 200; i++) begin
                    rd(2'd0, st);
                    if (st[1]) break;
                end
                check("R8 done bit after check", st[1], 1);
                rd(2'd1, ec);
                pop = exp_q.pop_front();
                check("R5 error count", ec, pop);
                mon_runs++;
                while (irq) @(negedge sys_clk);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge sys_clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int v;
        repeat (6) @(negedge rx_clk);
        rx_rst = 0;
        sys_wait(6);
        sys_rst = 0;
        sys_wait(2);
        rd(2'd0, v); check("R1 status after reset", v, 0);
        rd(2'd1, v); check("R1 error count after reset", v, 0);
        check("R1 irq after reset", irq, 0);

        // run A: clean pattern with unscheduled junk in between (R2)
        start_run(16'hACE1);
        for (int i = 0; i < DEPTH - 1; i++) begin
            send(16'hDEAD, 1, 0);
            send(16'hBEEF, 0, 1);
            send(g, 1, 1); g = lfsr_step(g);
        end
        rx_idle();
        sys_wait(12);
        check("R9 irq one word short", irq, 0);
        rd(2'd0, v); check("R9 full bit one word short", v[2], 0);
        send(g, 1, 1);
        for (int i = 0; i < 4; i++) send(16'h5555, 1, 1);   // R3 junk after full
        rx_idle();
        wait_runs(1);
        check("R4 irq after full", irq, 1);
        rd(2'd0, v); check("R8 status full+done+irq", v, 7);
        rd(2'd1, v); check("R2 R3 clean run count", v, 0);
        sys_wait(40);
        check("R4 irq held", irq, 1);
        clear();
        check("R7 irq cleared", irq, 0);
        rd(2'd1, v); check("R7 count cleared", v, 0);
        sys_wait(6);
        rd(2'd0, v); check("R7 status cleared", v, 0);

        // run B: scattered bit flips
        start_run(16'h1234);
        for (int i = 0; i < DEPTH; i++) begin
            bit [15:0] f;
            f = (i == 3) ? 16'h00FF : ((i % 5 == 0) ? 16'h8001 : 16'h0000);
            send(g ^ f, 1, 1); g = lfsr_step(g);
        end
        rx_idle();
        wait_runs(2);
        rd(2'd1, v); check("R5 flipped count", v, 8 + 4 * 2);
        clear();

        // run C: every bit wrong, 256 errors saturate (R6)
        start_run(16'hBEEF);
        for (int i = 0; i < DEPTH; i++) begin
            send(~g, 1, 1); g = lfsr_step(g);
        end
        rx_idle();
        wait_runs(3);
        rd(2'd1, v); check("R6 saturated count", v, ERR_MAX);
        clear();

        // run D: clear mid-run, then a clean run must start at entry 0 (R7)
        start_run(16'h5A5A);
        for (int i = 0; i < 5; i++) send(16'hFFFF, 1, 1);
        rx_idle();
        clear();
        start_run(16'h5A5A);
        for (int i = 0; i < DEPTH; i++) begin
            send(g, 1, 1); g = lfsr_step(g);
        end
        rx_idle();
        wait_runs(4);
        rd(2'd1, v); check("R7 rearmed pointer clean count", v, 0);
        check("R4 irq after rearmed run", irq, 1);
        clear();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule